// File: doc/BRIEF.md
# Synchronized Phase Offset Modulator

This block shifts the quantized phase of a numerically controlled oscillator by an 8-bit offset word. An external agent writes the offset word with its own active-low strobe, which has no timing relation to the oscillator clock. The word is latched by that strobe's rising edge. The strobe level is then brought into the clock domain, and its rising edge turns into a single-cycle load pulse. That pulse copies the latched word into the synchronized offset register.

Each clock cycle, the synchronized offset is added to the incoming accumulator phase modulo 256, and the sum is registered. Two single-bit quadrature square waves are taken from the registered sum. They follow the unshifted square waves, advanced by 2π/256 times the offset word. Amplitude lookup takes place downstream and is not part of this block.

Top module: `phase_offset_mod`

## Requirements
- R1: While `rst` is high at a clock edge, `sync_word` and `mod_phase` clear to 0, so `msin` reads 0 and `mcos` reads 1. The synchronizer is set to the idle (high) strobe level.
- R2: `word_in` is latched only at the rising edge of `word_wr_n`. Changes to `word_in` at any other moment have no effect on the word that is later loaded.
- R3: After a rising edge of `word_wr_n`, `sync_word` keeps its old value through the first rising clock edge. It takes the latched word at the second rising clock edge.
- R4: At every clock edge outside reset, `mod_phase` is loaded with (`acc_phase` + `sync_word`) mod 256, using the values present before that edge. The carry is dropped. In a cycle where a new word loads, the sum still uses the old word.
- R5: `msin` equals bit 7 of `mod_phase`.
- R6: `mcos` is 1 when bits 7 and 6 of `mod_phase` are equal, and 0 otherwise.
- R7: A falling edge of `word_wr_n`, or a strobe held low for any number of cycles, loads nothing into `sync_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| word_wr_n | input | 1 | Asynchronous active-low write strobe for the offset word |
| word_in | input | 8 | Offset word, latched on the strobe's rising edge |
| acc_phase | input | 8 | Quantized phase from the accumulator |
| sync_word | output | 8 | Offset word in the clock domain |
| mod_phase | output | 8 | Registered offset phase |
| msin | output | 1 | Square sine taken from the offset phase |
| mcos | output | 1 | Square cosine taken from the offset phase |

## Verification
A new offset word can land in `sync_word` at the same clock edge in which the adder registers its sum, so two operations coincide in one cycle. The bench provokes this by setting `acc_phase` just before the second clock edge that follows a strobe rise. It then checks two things after that edge. First, `sync_word` shows the new word. Second, `mod_phase` equals the accumulator value plus the previous word. In the next cycle, `mod_phase` must reflect the new word.

// File: rtl/phase_offset_mod.sv
module phase_offset_mod #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         word_wr_n,
  input  logic [W-1:0] word_in,
  input  logic [W-1:0] acc_phase,
  output logic [W-1:0] sync_word,
  output logic [W-1:0] mod_phase,
  output logic         msin,
  output logic         mcos
);

  logic [W-1:0] cap_word;
  logic         strb_meta, strb_sync;
  logic         load;

  always_ff @(posedge word_wr_n)
    cap_word <= word_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_meta <= 1'b1;
      strb_sync <= 1'b1;
    end else begin
      strb_meta <= word_wr_n;
      strb_sync <= strb_meta;
    end
  end

  assign load = strb_meta & ~strb_sync;

  always_ff @(posedge clk) begin
    if (rst)       sync_word <= '0;
    else if (load) sync_word <= cap_word;
  end

  always_ff @(posedge clk) begin
    if (rst) mod_phase <= '0;
    else     mod_phase <= acc_phase + sync_word;
  end

  assign msin = mod_phase[W-1];
  assign mcos = ~(mod_phase[W-1] ^ mod_phase[W-2]);

endmodule

// File: rtl/phase_offset_mod_chk.sv
module phase_offset_mod_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         word_wr_n,
  input logic [W-1:0] acc_phase,
  input logic [W-1:0] sync_word,
  input logic [W-1:0] mod_phase,
  input logic         msin,
  input logic         mcos
);

  logic [W-1:0] sum_in;
  assign sum_in = acc_phase + sync_word;

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (sync_word == '0 && mod_phase == '0));

  // R4
  a_r4_wrap_sum: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> mod_phase == $past(sum_in));

  // R5
  a_r5_sine_bit: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> msin == $past(sum_in[W-1]));

  // R6
  a_r6_cos_bit: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> mcos == ($past(sum_in[W-1]) == $past(sum_in[W-2])));

  // R3, R7
  a_r3_load_after_rise: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && sync_word != $past(sync_word))
      |-> ($past(word_wr_n, 2) && !$past(word_wr_n, 3)));

endmodule

bind phase_offset_mod phase_offset_mod_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .word_wr_n(word_wr_n), .acc_phase(acc_phase),
  .sync_word(sync_word), .mod_phase(mod_phase), .msin(msin), .mcos(mcos)
);

// File: tb/sim_phase_offset_mod.sv
`timescale 1ns/1ps
module sim_phase_offset_mod;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       word_wr_n = 1'b1;
  logic [7:0] word_in = 8'h00;
  logic [7:0] acc_phase = 8'h00;
  logic [7:0] sync_word, mod_phase;
  logic       msin, mcos;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phase_offset_mod u0 (
    .clk(clk), .rst(rst), .word_wr_n(word_wr_n), .word_in(word_in),
    .acc_phase(acc_phase), .sync_word(sync_word), .mod_phase(mod_phase),
    .msin(msin), .mcos(mcos)
  );

  localparam int NV = 9;
  localparam logic [7:0] VW [NV] = '{8'h00, 8'h10, 8'h40, 8'h80, 8'hC0, 8'hFF, 8'hF0, 8'h7F, 8'h3F};
  localparam logic [7:0] VA [NV] = '{8'h00, 8'h20, 8'h00, 8'h05, 8'h01, 8'h01, 8'h20, 8'h81, 8'h01};
  localparam logic [7:0] VE [NV] = '{8'h00, 8'h30, 8'h40, 8'h85, 8'hC1, 8'h00, 8'h10, 8'h00, 8'h40};

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_sq(string tag, logic [7:0] ph);
    check({tag, " R5 msin"}, {7'd0, msin}, {7'd0, ph[7]});
    check({tag, " R6 mcos"}, {7'd0, mcos}, {7'd0, ph[7] == ph[6]});
  endtask

  // strobe low then high; the rise happens at a falling clock edge
  task automatic strobe(logic [7:0] w);
    @(negedge clk);
    word_in = w;
    word_wr_n = 1'b0;
    @(negedge clk);
    word_wr_n = 1'b1;
    #0.5 word_in = ~w;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 sync_word", sync_word, 8'h00);
    check("R1 mod_phase", mod_phase, 8'h00);
    check_sq("R1", 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      prev = sync_word;
      strobe(VW[i]);
      acc_phase = VA[i];
      @(negedge clk);
      check("R3 not yet loaded", sync_word, prev);
      @(negedge clk);
      check("R3 R2 loaded", sync_word, VW[i]);
      check("R4 old word in load cycle", mod_phase, VA[i] + prev);
      @(negedge clk);
      check("R4 table sum", mod_phase, VE[i]);
      check_sq("table", VE[i]);
    end

    // R7: strobe held low, no load
    @(negedge clk);
    prev = sync_word;
    word_in = 8'h5A;
    word_wr_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 held low", sync_word, prev);
    word_in = 8'h22;
    repeat (2) @(negedge clk);
    check("R7 held low after word change", sync_word, prev);
    word_wr_n = 1'b1;
    #0.5 word_in = 8'h99;
    repeat (2) @(negedge clk);
    check("R2 rise latches last word", sync_word, 8'h22);

    // R4 tracking across several accumulator steps
    for (int k = 0; k < 8; k++) begin
      acc_phase = 8'(k * 37 + 200);
      @(negedge clk);
      check("R4 sweep", mod_phase, 8'(k * 37 + 200 + 8'h22));
      check_sq("sweep", 8'(k * 37 + 200 + 8'h22));
    end

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run sync_word", sync_word, 8'h00);
    check("R1 mid-run mod_phase", mod_phase, 8'h00);
    rst = 1'b0;
    acc_phase = 8'hC3;
    @(negedge clk);
    check("R1 no spurious load after reset", sync_word, 8'h00);
    check("R4 after reset", mod_phase, 8'hC3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule